// File: doc/BRIEF.md
# Bus-Mastering Ones'-Complement Checksum Engine

This block computes the 16-bit ones'-complement Internet checksum used by TCP over a payload that sits in data memory. Software writes a word-aligned base address and a byte count into a small register window and sets a start bit. From then on the engine fetches the payload over its own 32-bit read port. It folds the two 16-bit halves of each returned word into a wide accumulator in the same clock the word arrives. When the last word is in, it folds the carries back and stores the complemented 16-bit sum in a result register.

The processor does not move any payload data. It may do other work and poll a status word for completion. Within each memory word the byte at the lowest address is the most significant byte (bits 31:24), so the upper half-word comes first in network order. A tail that is not a whole word has its unused low-order bytes forced to zero. A lone final byte therefore counts as the high byte of a zero-padded 16-bit unit.

Top module: `csum_engine`

## Requirements
- R1: After reset, the status word (offset 0x0C) and result (offset 0x10) read as zero, and the read request is low.
- R2: The base address register (offset 0x00) reads back with bits 1:0 forced to zero. The byte count register (offset 0x04) reads back exactly as written.
- R3: After a start (offset 0x08, bit 0), the read port requests addresses base, base+4, base+8, and so on, one for each word covering the byte count (count/4 rounded up). It advances only on a cycle where the request is high and the wait input is low. It holds request and address steady while wait is high.
- R4: A word is summed only on cycles where the read-valid input is high. The result is the bitwise inverse of the end-around-carry sum of all 16-bit units. Each word supplies bits 31:16 and then bits 15:0.
- R5: When the byte count is not a multiple of four, the last word keeps only its top count%4 bytes, and the lower bytes count as zero.
- R6: A computed result of 0x0000 is reported as 0x0000, with no substitution.
- R7: A byte count of zero finishes with result 0xFFFF and issues no read request.
- R8: A start written while the engine is busy has no effect on the running job, its addresses or its result.
- R9: Status bit 0 (busy) is high from the cycle after an accepted start until completion. Status bit 1 (done) is set at completion and is never high together with busy. Writing offset 0x08 with bit 1 set clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| memReq | output | 1 | Read request |
| memAddr | output | 32 | Read byte address (word aligned) |
| memWait | input | 1 | Memory not accepting the request this cycle |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |

## Verification
Fixed payloads of one, two and three bytes show whether the tail mask keeps the correct byte lanes. Those lanes are backed by non-zero memory, so any leak changes the sum. A two-byte 0xFFFF payload separates correct reporting of a zero result from a substitution. A zero-length job separates the immediate-finish path from a path that starts a fetch. Random payloads of random length at random bases, with random wait stalls and a pipelined fixed-latency memory, test end-around carry folding over long sums. They also check the address sequence on every accepted request. A second start during a running job shows whether the control latches new arguments in mid-job.

// File: rtl/csum_pkg.sv
package csum_pkg;
  // Strobes from the sequencer to the accumulator datapath.
  typedef struct packed {
    logic clearAcc;   // new job: zero sum, latch tail size
    logic addEn;      // a payload word is valid this cycle
    logic lastWord;   // the valid word is the final one
    logic foldEn;     // fold carries back into the low 16 bits
    logic capture;    // store inverted sum in the result register
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FOLD = 2'd2
  } ctlState_t;

  localparam logic [4:0] OFS_ADDR   = 5'h00;
  localparam logic [4:0] OFS_LEN    = 5'h04;
  localparam logic [4:0] OFS_CTRL   = 5'h08;
  localparam logic [4:0] OFS_STATUS = 5'h0C;
  localparam logic [4:0] OFS_RESULT = 5'h10;
endpackage

// File: rtl/csum_ctrl.sv
module csum_ctrl
  import csum_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  lenBytes,
  input  logic              memWait,
  input  logic              memRdValid,
  input  logic              foldDone,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              busy,
  output logic              doneSet,
  output dpCtl_t            dpCtl
);
  localparam int CNT_W = LEN_W - 1;

  ctlState_t        state;
  logic [CNT_W-1:0] issueLeft;
  logic [CNT_W-1:0] recvLeft;
  logic [CNT_W-1:0] wordCount;
  logic             accepted;

  assign wordCount = CNT_W'(lenBytes[LEN_W-1:2]) + CNT_W'(lenBytes[1:0] != 2'b00);
  assign memReq    = (state == ST_RUN) && (issueLeft != '0);
  assign accepted  = memReq && !memWait;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    dpCtl          = '0;
    dpCtl.clearAcc = (state == ST_IDLE) && startPulse;
    dpCtl.addEn    = (state == ST_RUN) && memRdValid && (recvLeft != '0);
    dpCtl.lastWord = (recvLeft == CNT_W'(1));
    dpCtl.foldEn   = (state == ST_FOLD);
    dpCtl.capture  = (state == ST_FOLD) && foldDone;
    doneSet        = dpCtl.capture;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      issueLeft <= '0;
      recvLeft  <= '0;
      memAddr   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startPulse) begin
          state     <= ST_RUN;
          issueLeft <= wordCount;
          recvLeft  <= wordCount;
          memAddr   <= startAddr;
        end
        ST_RUN: begin
          if (accepted) begin
            issueLeft <= issueLeft - CNT_W'(1);
            memAddr   <= memAddr + ADDR_W'(4);
          end
          if (recvLeft == '0) begin
            state <= ST_FOLD;
          end else if (memRdValid) begin
            recvLeft <= recvLeft - CNT_W'(1);
            if (recvLeft == CNT_W'(1)) state <= ST_FOLD;
          end
        end
        ST_FOLD: if (foldDone) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csum_datapath.sv
module csum_datapath
  import csum_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      dpCtl,
  input  logic [1:0]  tailIn,
  input  logic [31:0] memRdData,
  output logic        foldDone,
  output logic [15:0] result
);
  // Worst case: 2^(LEN_W-2) words each adding below 2^17.
  localparam int NEED_W = LEN_W + 15;
  localparam int ACC_W  = (NEED_W > 34) ? NEED_W : 34;

  logic [ACC_W-1:0] acc;
  logic [1:0]       tailBytes;
  logic [31:0]      laneMask;
  logic [31:0]      maskedWord;

  always_comb begin
    laneMask = 32'hFFFF_FFFF;
    if (dpCtl.lastWord && tailBytes != 2'b00)
      laneMask = ~(32'hFFFF_FFFF >> (6'd8 * {4'd0, tailBytes}));
    maskedWord = memRdData & laneMask;
  end

  assign foldDone = (acc[ACC_W-1:16] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      tailBytes <= '0;
      result    <= '0;
    end else begin
      if (dpCtl.clearAcc) begin
        acc       <= '0;
        tailBytes <= tailIn;
      end else if (dpCtl.addEn) begin
        acc <= acc + ACC_W'(maskedWord[31:16]) + ACC_W'(maskedWord[15:0]);
      end else if (dpCtl.foldEn && !foldDone) begin
        acc <= ACC_W'(acc[15:0]) + ACC_W'(acc[ACC_W-1:16]);
      end
      if (dpCtl.capture) result <= ~acc[15:0];
    end
  end
endmodule

// File: rtl/csum_engine.sv
module csum_engine
  import csum_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memWait,
  input  logic        memRdValid,
  input  logic [31:0] memRdData
);
  logic [ADDR_W-1:0] baseReg;
  logic [LEN_W-1:0]  lenReg;
  logic              doneFlag;
  logic              busy;
  logic              doneSet;
  logic              foldDone;
  logic              startPulse;
  logic              ctrlWr;
  logic [15:0]       result;
  logic [ADDR_W-1:0] rdAddr;
  dpCtl_t            dpCtl;

  assign ctrlWr     = regWrEn && (regAddr == OFS_CTRL);
  assign startPulse = ctrlWr && regWrData[0] && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg  <= '0;
      lenReg   <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (regWrEn && regAddr == OFS_ADDR) baseReg <= {regWrData[ADDR_W-1:2], 2'b00};
      if (regWrEn && regAddr == OFS_LEN)  lenReg  <= regWrData[LEN_W-1:0];
      if (doneSet)                                doneFlag <= 1'b1;
      else if (startPulse || (ctrlWr && regWrData[1])) doneFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      OFS_ADDR:   regRdData = 32'(baseReg);
      OFS_LEN:    regRdData = 32'(lenReg);
      OFS_STATUS: regRdData = {30'd0, doneFlag, busy};
      OFS_RESULT: regRdData = {16'd0, result};
      default:    regRdData = '0;
    endcase
  end

  csum_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startAddr(baseReg),
    .lenBytes(lenReg), .memWait(memWait), .memRdValid(memRdValid),
    .foldDone(foldDone), .memReq(memReq), .memAddr(rdAddr), .busy(busy),
    .doneSet(doneSet), .dpCtl(dpCtl)
  );

  csum_datapath #(.LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .tailIn(lenReg[1:0]),
    .memRdData(memRdData), .foldDone(foldDone), .result(result)
  );

  assign memAddr = 32'(rdAddr);
endmodule

// File: rtl/csum_engine_chk.sv
module csum_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memWait,
  input logic [31:0] memAddr,
  input logic [31:0] regRdData,
  input logic [4:0]  regAddr,
  input logic        busy,
  input logic        doneFlag
);
  // A stalled request must be held with the same address.
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWait) |=> (memReq && $stable(memAddr)));

  // The address after an accepted request is the next word.
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWait) |=> (!memReq || memAddr == $past(memAddr) + 32'd4));

  // Done and busy are never raised together.
  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && doneFlag));

  // No request is issued once the job has finished.
  assert_no_req_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !memReq);

  // The status read mirrors busy.
  assert_status_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 5'h0C) |-> (regRdData[0] == busy));

  // No fetch happens while idle.
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);
endmodule

bind csum_engine csum_engine_chk uChk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWait(memWait),
  .memAddr(memAddr), .regRdData(regRdData), .regAddr(regAddr),
  .busy(busy), .doneFlag(doneFlag)
);

// File: tb/tb_csum_engine.sv
`timescale 1ns/1ps
module tb_csum_engine;
  localparam int LAT = 3;
  localparam int MEM_BYTES = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memWait = 1'b0;
  logic        memRdValid;
  logic [31:0] memRdData;

  logic [7:0]  mem [MEM_BYTES];
  logic        vldP [LAT];
  logic [31:0] datP [LAT];
  int          checks = 0;
  int          fails = 0;
  int          cycles = 0;
  int          waitPct = 30;
  logic [31:0] expAddrQ [$];

  always #2.5 clk = ~clk;

  csum_engine dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memAddr(memAddr), .memWait(memWait), .memRdValid(memRdValid),
    .memRdData(memRdData)
  );

  // Fixed-latency pipelined memory, lowest address in bits 31:24.
  always @(posedge clk) begin
    for (int i = LAT - 1; i > 0; i--) begin
      vldP[i] <= vldP[i-1];
      datP[i] <= datP[i-1];
    end
    vldP[0] <= memReq && !memWait;
    datP[0] <= {mem[memAddr[9:0]], mem[memAddr[9:0] + 10'd1],
                mem[memAddr[9:0] + 10'd2], mem[memAddr[9:0] + 10'd3]};
  end
  assign memRdValid = vldP[LAT-1];
  assign memRdData  = datP[LAT-1];

  initial forever begin
    @(posedge clk);
    #1 memWait = ($urandom_range(99) < waitPct);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-cycle model of the fetch sequence (R3, R8, R7).
  always @(negedge clk) begin
    cycles++;
    if (rstN && memReq && !memWait) begin
      if (expAddrQ.size() == 0) check(0, "R3 unexpected request", memAddr, 32'hx);
      else begin
        logic [31:0] e;
        e = expAddrQ.pop_front();
        check(memAddr == e, "R3 address", memAddr, e);
      end
    end
  end

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [15:0] refSum(input int base, input int len);
    int s = 0;
    for (int i = 0; i < len; i += 2) begin
      int lo = (i + 1 < len) ? int'(mem[base + i + 1]) : 0;
      s += (int'(mem[base + i]) << 8) + lo;
    end
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic waitDone(output logic [31:0] st);
    int n = 0;
    do begin rdReg(5'h0C, st); n++; end while (!st[1] && n < 20000);
  endtask

  task automatic runJob(input int base, input int len, input string req);
    logic [31:0] st, res;
    logic [15:0] exp;
    exp = refSum(base, len);
    for (int w = 0; w < (len + 3) / 4; w++) expAddrQ.push_back(32'(base + 4 * w));
    wrReg(5'h00, 32'(base));
    wrReg(5'h04, 32'(len));
    wrReg(5'h08, 32'h1);
    waitDone(st);
    check(st == 32'h2, {req, " status done"}, st, 32'h2);
    rdReg(5'h10, res);
    check(res == {16'd0, exp}, {req, " result"}, res, {16'd0, exp});
    check(expAddrQ.size() == 0, {req, " all words fetched"}, 32'(expAddrQ.size()), 0);
    expAddrQ.delete();
  endtask

  initial begin
    #50000000;
    check(0, "watchdog", 32'(cycles), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, st;
    logic [15:0] exp;
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < LAT; i++) begin vldP[i] = 1'b0; datP[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    rdReg(5'h0C, v); check(v == 0, "R1 status", v, 0);
    rdReg(5'h10, v); check(v == 0, "R1 result", v, 0);
    check(memReq == 1'b0, "R1 request", 32'(memReq), 0);
    rstN = 1'b1;
    // R2: register readback
    wrReg(5'h00, 32'h0000_0107); rdReg(5'h00, v); check(v == 32'h104, "R2 base", v, 32'h104);
    wrReg(5'h04, 32'h0000_1235); rdReg(5'h04, v); check(v == 32'h1235, "R2 length", v, 32'h1235);
    // R7: zero length
    runJob(32'h40, 0, "R7 zero length");
    rdReg(5'h10, v); check(v == 32'hFFFF, "R7 value", v, 32'hFFFF);
    // R9: clear done
    wrReg(5'h08, 32'h2); rdReg(5'h0C, v); check(v == 0, "R9 clear done", v, 0);
    // R5: tails of one, two and three bytes
    runJob(32'h80, 1, "R5 one byte");
    runJob(32'h84, 2, "R5 two bytes");
    runJob(32'h88, 3, "R5 three bytes");
    runJob(32'h8C, 7, "R5 seven bytes");
    // R6: zero result kept
    mem[32'h200] = 8'hFF; mem[32'h201] = 8'hFF;
    runJob(32'h200, 2, "R6 zero result");
    rdReg(5'h10, v); check(v == 0, "R6 value", v, 0);
    // R9: busy during job; R8: second start ignored
    exp = refSum(32'h100, 200);
    for (int w = 0; w < 50; w++) expAddrQ.push_back(32'h100 + 32'(4 * w));
    wrReg(5'h00, 32'h100); wrReg(5'h04, 32'd200); wrReg(5'h08, 32'h1);
    rdReg(5'h0C, v); check(v == 32'h1, "R9 busy", v, 32'h1);
    wrReg(5'h00, 32'h300); wrReg(5'h04, 32'd8); wrReg(5'h08, 32'h1);
    waitDone(st);
    rdReg(5'h10, v); check(v == {16'd0, exp}, "R8 result unchanged", v, {16'd0, exp});
    check(expAddrQ.size() == 0, "R8 sequence", 32'(expAddrQ.size()), 0);
    expAddrQ.delete();
    // R4: random payloads, including an all-ones run for carry folding
    for (int i = 0; i < 64; i++) mem[32'h300 + i] = 8'hFF;
    runJob(32'h300, 64, "R4 all ones");
    for (int k = 0; k < 25; k++) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'($urandom);
      waitPct = (k % 3 == 0) ? 0 : 40;
      runJob(4 * $urandom_range(128), $urandom_range(400), "R4 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule